// File: doc/BRIEF.md
# Predicate Flag Bank with Guarded Dual Issue

This block replaces short conditional branches with guarded execution. It holds a bank of one-bit predicate flags. A compare-result port writes a complementary pair of flags in one cycle: the condition goes to one target index and its inverse goes to the other. Instructions for both arms of a condition can then be issued together. Each instruction names one qualifying flag. A one-cycle read stage passes the instruction on as committed when that flag is 1. When the flag is 0 it marks the instruction as a no-operation. Fetch is never redirected and the pipeline is never flushed.

Flag 0 is fixed at 1, so unguarded instructions name it. When a compare and an issue meet on the same flag in the same cycle, the compare result is forwarded to the reader. The block does not decode instructions, evaluate compares or execute the guarded operations. It only carries an opaque payload beside each lane.

Top module: `pred_guard_unit`

## Requirements
- R1: The bank holds NUM_PRED (default 64) flags. A compare changes only the flags it targets, so each index can be written independently of every other index.
- R2: A compare with `cmp_valid`=1 writes `cmp_cond` to flag `cmp_dst_a` and the inverse of `cmp_cond` to flag `cmp_dst_b` at the same clock edge.
- R3: Flag 0 always reads as 1. Compare writes aimed at index 0 are discarded, and the other target of that compare is still written.
- R4: When `cmp_dst_a` equals `cmp_dst_b`, that flag takes the value of `cmp_cond`.
- R5: An issued instruction whose flag reads 0 appears one cycle later with `out_valid`=0 and `out_nullified`=1.
- R6: An issued instruction whose flag reads 1 appears one cycle later with `out_valid`=1 and `out_nullified`=0, and its payload appears on `out_op`.
- R7: When a compare targets the index a lane reads in the same cycle, the lane uses the value being written. Target a takes priority over target b.
- R8: While `rst_n` is low, all flags except flag 0 clear to 0 and both lane outputs go idle (`out_valid`=0, `out_nullified`=0).
- R9: A lane with `iss_valid`=0 shows `out_valid`=0 and `out_nullified`=0 in the next cycle.
- R10: Both lanes resolve independently in the same cycle. One may commit while the other is nullified.
- R11: `out_valid` and `out_nullified` of a lane are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare result present this cycle |
| cmp_dst_a | input | IDX_W | Index that receives the condition |
| cmp_dst_b | input | IDX_W | Index that receives the inverted condition |
| cmp_cond | input | 1 | Compare outcome |
| iss_valid | input | LANES | Per-lane issue strobe |
| iss_pred | input | LANES*IDX_W | Per-lane qualifying flag index, lane 0 in the low bits |
| iss_op | input | LANES*OP_W | Per-lane opaque instruction payload |
| out_valid | output | LANES | Lane committed, one cycle after issue |
| out_nullified | output | LANES | Lane turned into a no-operation |
| out_op | output | LANES*OP_W | Payload of the resolved instruction |

## Verification
Two functions can fall in the same cycle: a compare writing the flag pair, and a lane reading one of those same flags. The stimulus routinely aims lane 0 at target a and lane 1 at target b of the compare issued in that cycle. Now and then both targets are set equal, or one of them is set to index 0. The bench keeps its own flag model and computes the value the lane must see from the requirement rules, giving target a priority and treating flag 0 as fixed. It then judges the commit and nullify bits one cycle later against that value. A later sweep reads every index to confirm that the bank holds exactly the writes the model predicts.

// File: rtl/pred_guard_pkg.sv
package pred_guard_pkg;
  localparam int unsigned DEF_NUM_PRED = 64;
  localparam int unsigned DEF_LANES    = 2;
  localparam int unsigned DEF_OP_W     = 8;

  typedef struct packed {
    logic commit;
    logic squash;
  } lane_fate_t;

  function automatic lane_fate_t resolve_fate(input logic issued, input logic flag);
    lane_fate_t f;
    f.commit = issued & flag;
    f.squash = issued & ~flag;
    return f;
  endfunction
endpackage

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int unsigned NUM_PRED = 64,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx_a,
  input  logic [IDX_W-1:0]    wr_idx_b,
  input  logic                wr_cond,
  output logic [NUM_PRED-1:0] flags
);
  logic [NUM_PRED-1:0] flags_nxt;

  // entry 0 is hardwired true; others take target a over target b
  assign flags_nxt[0] = 1'b1;

  for (genvar k = 1; k < NUM_PRED; k++) begin : g_entry
    always_comb begin
      flags_nxt[k] = flags[k];
      if (wr_idx_b == IDX_W'(k)) flags_nxt[k] = ~wr_cond;
      if (wr_idx_a == IDX_W'(k)) flags_nxt[k] = wr_cond;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= {{(NUM_PRED-1){1'b0}}, 1'b1};
    end else if (wr_en) begin
      flags <= flags_nxt;
    end
  end
endmodule

// File: rtl/pred_lane.sv
module pred_lane
  import pred_guard_pkg::*;
#(
  parameter int unsigned NUM_PRED = 64,
  parameter int unsigned OP_W     = 8,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PRED-1:0] flags,
  input  logic                cmp_valid,
  input  logic [IDX_W-1:0]    cmp_dst_a,
  input  logic [IDX_W-1:0]    cmp_dst_b,
  input  logic                cmp_cond,
  input  logic                iss_valid,
  input  logic [IDX_W-1:0]    iss_idx,
  input  logic [OP_W-1:0]     iss_op,
  output logic                out_valid,
  output logic                out_nullified,
  output logic [OP_W-1:0]     out_op
);
  logic       is_zero;
  logic       hit_a;
  logic       hit_b;
  logic       flag_now;
  lane_fate_t fate_nxt;

  // bypass the compare result when it targets the index being read
  always_comb begin
    is_zero = (iss_idx == '0);
    hit_a   = cmp_valid & (cmp_dst_a == iss_idx);
    hit_b   = cmp_valid & (cmp_dst_b == iss_idx);
    if (is_zero)    flag_now = 1'b1;
    else if (hit_a) flag_now = cmp_cond;
    else if (hit_b) flag_now = ~cmp_cond;
    else            flag_now = flags[iss_idx];
    fate_nxt = resolve_fate(iss_valid, flag_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_nullified <= 1'b0;
    end else begin
      out_valid     <= fate_nxt.commit;
      out_nullified <= fate_nxt.squash;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_op <= '0;
    end else if (iss_valid) begin
      out_op <= iss_op;
    end
  end
endmodule

// File: rtl/pred_guard_unit.sv
module pred_guard_unit
  import pred_guard_pkg::*;
#(
  parameter int unsigned NUM_PRED = DEF_NUM_PRED,
  parameter int unsigned LANES    = DEF_LANES,
  parameter int unsigned OP_W     = DEF_OP_W,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmp_valid,
  input  logic [IDX_W-1:0]        cmp_dst_a,
  input  logic [IDX_W-1:0]        cmp_dst_b,
  input  logic                    cmp_cond,
  input  logic [LANES-1:0]        iss_valid,
  input  logic [LANES*IDX_W-1:0]  iss_pred,
  input  logic [LANES*OP_W-1:0]   iss_op,
  output logic [LANES-1:0]        out_valid,
  output logic [LANES-1:0]        out_nullified,
  output logic [LANES*OP_W-1:0]   out_op
);
  logic [NUM_PRED-1:0] pred_bits;

  pred_bank #(.NUM_PRED(NUM_PRED)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmp_valid),
    .wr_idx_a (cmp_dst_a),
    .wr_idx_b (cmp_dst_b),
    .wr_cond  (cmp_cond),
    .flags    (pred_bits)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pred_lane #(.NUM_PRED(NUM_PRED), .OP_W(OP_W)) u_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .flags         (pred_bits),
      .cmp_valid     (cmp_valid),
      .cmp_dst_a     (cmp_dst_a),
      .cmp_dst_b     (cmp_dst_b),
      .cmp_cond      (cmp_cond),
      .iss_valid     (iss_valid[l]),
      .iss_idx       (iss_pred[l*IDX_W +: IDX_W]),
      .iss_op        (iss_op[l*OP_W +: OP_W]),
      .out_valid     (out_valid[l]),
      .out_nullified (out_nullified[l]),
      .out_op        (out_op[l*OP_W +: OP_W])
    );
  end
endmodule

// File: rtl/pred_guard_checker.sv
module pred_guard_checker #(
  parameter int unsigned NUM_PRED = 64,
  parameter int unsigned LANES    = 2,
  parameter int unsigned OP_W     = 8,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmp_valid,
  input logic [IDX_W-1:0]        cmp_dst_a,
  input logic [IDX_W-1:0]        cmp_dst_b,
  input logic                    cmp_cond,
  input logic [LANES-1:0]        iss_valid,
  input logic [LANES*IDX_W-1:0]  iss_pred,
  input logic [LANES*OP_W-1:0]   iss_op,
  input logic [LANES-1:0]        out_valid,
  input logic [LANES-1:0]        out_nullified,
  input logic [LANES*OP_W-1:0]   out_op,
  input logic [NUM_PRED-1:0]     pred_bits
);
  a_r3_zero_true: assert property (@(posedge clk) disable iff (!rst_n)
    pred_bits[0]);

  a_r2_pair_written: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_dst_a != cmp_dst_b && cmp_dst_a != '0 && cmp_dst_b != '0)
    |=> (pred_bits[$past(cmp_dst_a)] == $past(cmp_cond)) &&
        (pred_bits[$past(cmp_dst_b)] == !$past(cmp_cond)));

  a_r4_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_dst_a == cmp_dst_b && cmp_dst_a != '0)
    |=> pred_bits[$past(cmp_dst_a)] == $past(cmp_cond));

  a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(pred_bits));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid[l] && out_nullified[l]));

    a_r9_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid[l] |=> !out_valid[l] && !out_nullified[l]);

    a_r5_resolved: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[l] |=> out_valid[l] || out_nullified[l]);

    a_r6_payload: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[l] |=> out_op[l*OP_W +: OP_W] == $past(iss_op[l*OP_W +: OP_W]));

    a_r3_unguarded_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[l] && iss_pred[l*IDX_W +: IDX_W] == '0) |=> out_valid[l]);
  end
endmodule

bind pred_guard_unit pred_guard_checker #(
  .NUM_PRED(NUM_PRED), .LANES(LANES), .OP_W(OP_W)
) u_pred_guard_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmp_valid     (cmp_valid),
  .cmp_dst_a     (cmp_dst_a),
  .cmp_dst_b     (cmp_dst_b),
  .cmp_cond      (cmp_cond),
  .iss_valid     (iss_valid),
  .iss_pred      (iss_pred),
  .iss_op        (iss_op),
  .out_valid     (out_valid),
  .out_nullified (out_nullified),
  .out_op        (out_op),
  .pred_bits     (pred_bits)
);

// File: tb/test_pred_guard_unit.sv
module test_pred_guard_unit;
  localparam int NP = 64;
  localparam int IW = 6;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [IW-1:0] cmp_dst_a = '0;
  logic [IW-1:0] cmp_dst_b = '0;
  logic          cmp_cond = 1'b0;
  logic [1:0]    iss_valid = '0;
  logic [2*IW-1:0] iss_pred = '0;
  logic [2*OW-1:0] iss_op = '0;
  logic [1:0]    out_valid;
  logic [1:0]    out_nullified;
  logic [2*OW-1:0] out_op;

  int checks = 0;
  int failures = 0;
  bit model [NP];
  bit done = 1'b0;

  always #5 clk = ~clk;

  pred_guard_unit i_pred_guard_unit (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_dst_a(cmp_dst_a),
    .cmp_dst_b(cmp_dst_b), .cmp_cond(cmp_cond), .iss_valid(iss_valid),
    .iss_pred(iss_pred), .iss_op(iss_op), .out_valid(out_valid),
    .out_nullified(out_nullified), .out_op(out_op)
  );

  task automatic chk(input string tag, input int lane, input bit ev, input bit en,
                     input logic [OW-1:0] eop, input bit cop);
    checks++;
    if (out_valid[lane] !== ev || out_nullified[lane] !== en ||
        (cop && out_op[lane*OW +: OW] !== eop)) begin
      failures++;
      $display("FAIL %s lane%0d: valid/null/op got %b/%b/%h expected %b/%b/%h",
               tag, lane, out_valid[lane], out_nullified[lane],
               out_op[lane*OW +: OW], ev, en, eop);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NP; k++) model[k] = (k == 0);
  endtask

  // one cycle: drive at negedge, check the registered result at the next negedge
  task automatic step(input bit cv, input int a, input int b, input bit c,
                      input bit v0, input int i0, input bit v1, input int i1,
                      input logic [7:0] opb, input string hint);
    bit f[2]; string tg[2]; int ix[2]; bit vv[2];
    ix[0] = i0; ix[1] = i1; vv[0] = v0; vv[1] = v1;
    cmp_valid = cv; cmp_dst_a = IW'(a); cmp_dst_b = IW'(b); cmp_cond = c;
    iss_valid = {v1, v0};
    iss_pred = {IW'(i1), IW'(i0)};
    iss_op = {opb ^ 8'h5A, opb};
    for (int l = 0; l < 2; l++) begin
      if (ix[l] == 0) begin f[l] = 1'b1; tg[l] = "R3"; end
      else if (cv && a == ix[l]) begin f[l] = c; tg[l] = "R7"; end
      else if (cv && b == ix[l]) begin f[l] = !c; tg[l] = "R7"; end
      else begin f[l] = model[ix[l]]; tg[l] = f[l] ? "R6" : "R5"; end
      if (!vv[l]) tg[l] = "R9";
      if (hint != "") tg[l] = hint;
    end
    if (cv) begin
      if (b != 0) model[b] = !c;
      if (a != 0) model[a] = c;
    end
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      chk(tg[l], l, vv[l] & f[l], vv[l] & !f[l],
          (l == 0) ? opb : (opb ^ 8'h5A), vv[l]);
      if (vv[l] && (out_valid[l] & out_nullified[l])) begin
        failures++; $display("FAIL R11 lane%0d both bits set", l);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R8: outputs idle during reset
    chk("R8", 0, 1'b0, 1'b0, '0, 1'b0);
    chk("R8", 1, 1'b0, 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    // R8: every index after reset, two per cycle
    for (int k = 0; k < NP; k += 2)
      step(1'b0, 0, 0, 1'b0, 1'b1, k, 1'b1, k + 1, 8'(k), "R8");

    // R2, R10: pair written then read on both lanes
    step(1'b1, 10, 20, 1'b1, 1'b0, 0, 1'b0, 0, 8'h11, "R9");
    step(1'b0, 0, 0, 1'b0, 1'b1, 10, 1'b1, 20, 8'h22, "R2");
    step(1'b1, 10, 20, 1'b0, 1'b0, 0, 1'b0, 0, 8'h33, "R9");
    step(1'b0, 0, 0, 1'b0, 1'b1, 10, 1'b1, 20, 8'h44, "R10");
    // R4: same index on both targets, a wins
    step(1'b1, 30, 30, 1'b0, 1'b1, 30, 1'b0, 0, 8'h55, "R4");
    step(1'b0, 0, 0, 1'b0, 1'b1, 30, 1'b0, 0, 8'h66, "R4");
    step(1'b1, 30, 30, 1'b1, 1'b0, 0, 1'b1, 30, 8'h77, "R4");
    step(1'b0, 0, 0, 1'b0, 1'b1, 30, 1'b0, 0, 8'h88, "R4");
    // R3: write aimed at 0 discarded, other target still written
    step(1'b1, 0, 40, 1'b1, 1'b1, 0, 1'b1, 40, 8'h99, "R3");
    step(1'b0, 0, 0, 1'b0, 1'b1, 0, 1'b1, 40, 8'hAA, "R3");

    // mixed sweep with same-cycle forwarding
    for (int s = 0; s < 600; s++) begin
      int a = (s * 37 + 5) % NP;
      int b = (s % 11 == 0) ? a : (s * 13 + 7) % NP;
      int i0 = (s % 9 == 0) ? a : (s % 17 == 0) ? 0 : (s * 5) % NP;
      int i1 = (s % 6 == 0) ? b : (s * 29 + 1) % NP;
      step((s % 4) != 3, a, b, bit'((s * s + s / 3) % 2),
           (s % 7) != 6, i0, (s % 5) != 4, i1, 8'(s * 3), "");
    end

    // R1: full readback against the model
    for (int k = 0; k < NP; k += 2)
      step(1'b0, 0, 0, 1'b0, 1'b1, k, 1'b1, k + 1, 8'(k + 1), "R1");

    // mid-run reset, then R8 readback
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R8", 0, 1'b0, 1'b0, '0, 1'b0);
    chk("R8", 1, 1'b0, 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < NP; k += 2)
      step(1'b0, 0, 0, 1'b0, 1'b1, k, 1'b1, k + 1, 8'(k + 2), "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule